// File: doc/BRIEF.md
# SMBus Block-Transfer Slave

This block is the protocol layer of an SMBus target. A bit-level front end, outside this block, watches the bus wires. It hands the block decoded events: start (including repeated start), stop, a received byte, and a request for the next byte to transmit. For every received byte the block answers with an acknowledge decision one cycle later. For every transmit request it returns the byte to shift out one cycle later. Register contents live in an external register file that the block reaches through a plain address, write-data, write-enable and read-data port.

The first byte of a write frame is the command byte. It is kept in an address pointer, and bit 7 of that pointer chooses between single-byte and block transfers. Single-byte transfers cover send byte, write byte, read byte and receive byte. A block write carries a count byte and then data. A block read returns a count byte and then data. The block-read length is the value last written to register 0. Block data moves through consecutive register addresses, and the address wraps at the top of the register file. With packet error checking enabled, a CRC-8 covering every byte of the transaction is checked on writes and appended on reads.

Top module: `smb_blk_slave`

## Requirements
- R1: In a write frame, the byte after the address byte loads the pointer. If its bit 7 is 0, the next byte is written to the register at pointer bits [AW-1:0], the same cycle it is received, and it is acknowledged.
- R2: If bit 7 of the command byte is 1, the next byte is a count N. The N data bytes after it are written to consecutive registers starting at the pointer, and each one is acknowledged.
- R3: An address byte whose bits [7:1] match `dev_addr` is acknowledged, and its bit 0 set to 1 means a read frame. A non-matching address byte is not acknowledged, and every later byte of that frame is not acknowledged and writes nothing.
- R4: A committed write to register 0 sets the block length. A block read (bit 7 of the pointer set, then a read frame) transmits the count first and then data from consecutive registers starting at the pointer.
- R5: Block counts are limited to 32. In a block write, data bytes beyond 32 are not acknowledged and not written. A block read reports and sends min(length, 32) bytes.
- R6: Block addressing goes from register NREG-1 to register 0.
- R7: A read frame with bit 7 of the pointer clear returns the register at the pointer and leaves the pointer unchanged, so repeated reads return the same register.
- R8: When `pec_en` is 1, a CRC-8 is kept over every byte of the transaction, address bytes and bytes across a repeated start included. It uses polynomial 0x07, initial value 0x00 and MSB first, and it is sent after the last data byte of a read.
- R9: When `pec_en` is 1, a write byte commits only when the following PEC byte equals the CRC. A matching PEC is acknowledged and written. A mismatch is not acknowledged and the register is left unchanged.
- R10: Each received byte gets exactly one acknowledge response in the next cycle, and each transmit request gets a byte in the next cycle. Bytes received after a transfer has ended are not acknowledged, and transmit requests past the end return 0xFF. After reset no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 7 | Own 7-bit bus address |
| pec_en | input | 1 | Enable packet error checking |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| rx_valid | input | 1 | A byte was received |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Front end needs the next byte to transmit |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Transmit byte is valid |
| tx_byte | output | 8 | Byte to transmit |
| reg_addr | output | AW | Register file address (read and write) |
| reg_we | output | 1 | Register file write enable |
| reg_wdata | output | 8 | Register file write data |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
Two updates can fall in the same cycle: a block-write data byte committing to the register file, and the block-length copy updating because that same byte lands on register 0. The bench provokes this with a block write that starts two registers below the top of the file, so the address wraps and the third data byte hits register 0. A later block read from the same start must then report exactly that byte as its count and return the wrapped data in order. Random write-byte and read-byte traffic, with PEC switched on and off at random, is checked against a bench-side register image and a bit-serial CRC model.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_WPEC,
        ST_CNT,
        ST_BDATA,
        ST_BPEC,
        ST_READ,
        ST_TAIL
    } link_st_e;

    typedef enum logic [1:0] {
        RD_COUNT,
        RD_DATA,
        RD_PEC,
        RD_DONE
    } rd_ph_e;

    typedef struct packed {
        logic valid;
        logic ok;
    } ack_rsp_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } tx_rsp_t;

    localparam logic [7:0] PEC_POLY = 8'h07;
    localparam logic [7:0] IDLE_FILL = 8'hFF;

    // One byte of CRC-8, MSB first, byte-wide form
    function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ PEC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/smb_crc.sv
module smb_crc
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 8'h00;
        end else if (upd) begin
            crc <= crc8_byte(crc, din);
        end
    end
endmodule

// File: rtl/smb_ptr.sv
module smb_ptr #(
    parameter int NREG    = 96,
    parameter int MAX_BLK = 32,
    localparam int AW     = $clog2(NREG),
    localparam int CW     = $clog2(MAX_BLK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_ptr,
    input  logic [7:0]    ptr_in,
    input  logic          reload,
    input  logic          inc,
    input  logic          len_we,
    input  logic [7:0]    len_din,
    output logic          blk_mode,
    output logic [AW-1:0] wa,
    output logic [CW-1:0] len_clamp
);
    logic [7:0] ptr_q;
    logic [7:0] len_q;

    // Bring an AW-bit value into 0..NREG-1 (2^AW < 2*NREG)
    function automatic logic [AW-1:0] fold(input logic [AW-1:0] a);
        if (int'(a) >= NREG) begin
            return AW'(int'(a) - NREG);
        end
        return a;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= 8'h00;
            wa    <= '0;
        end else if (ld_ptr) begin
            ptr_q <= ptr_in;
            wa    <= fold(ptr_in[AW-1:0]);
        end else if (reload) begin
            wa    <= fold(ptr_q[AW-1:0]);
        end else if (inc) begin
            wa    <= (int'(wa) == NREG - 1) ? '0 : wa + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= 8'h00;
        end else if (len_we) begin
            len_q <= len_din;
        end
    end

    assign blk_mode  = ptr_q[7];
    assign len_clamp = (int'(len_q) > MAX_BLK) ? CW'(MAX_BLK) : CW'(len_q);
endmodule

// File: rtl/smb_fsm.sv
module smb_fsm
    import smb_pkg::*;
#(
    parameter int MAX_BLK = 32,
    localparam int CW     = $clog2(MAX_BLK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [6:0]    dev_addr,
    input  logic          pec_en,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_req,
    input  logic          blk_mode,
    input  logic [CW-1:0] len_clamp,
    input  logic [7:0]    crc,
    input  logic [7:0]    reg_rdata,
    output logic          ack_valid,
    output logic          ack_ok,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          reg_we,
    output logic [7:0]    reg_wdata,
    output logic          ld_ptr,
    output logic          reload,
    output logic          inc,
    output logic          crc_clr,
    output logic          crc_upd,
    output logic [7:0]    crc_din
);
    link_st_e      st_q, st_n;
    rd_ph_e        rd_q, rd_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [7:0]    wbuf_q, wbuf_n;
    ack_rsp_t      ack_q, ack_n;
    tx_rsp_t       tx_q, tx_n;
    logic [CW-1:0] cnt_rx;

    assign cnt_rx = (int'(rx_byte) > MAX_BLK) ? CW'(MAX_BLK) : CW'(rx_byte);

    always_comb begin
        st_n      = st_q;
        rd_n      = rd_q;
        cnt_n     = cnt_q;
        wbuf_n    = wbuf_q;
        ack_n     = '{valid: 1'b0, ok: 1'b0};
        tx_n      = '{valid: 1'b0, data: IDLE_FILL};
        reg_we    = 1'b0;
        reg_wdata = rx_byte;
        ld_ptr    = 1'b0;
        reload    = 1'b0;
        inc       = 1'b0;
        crc_clr   = 1'b0;
        crc_upd   = 1'b0;
        crc_din   = rx_byte;

        if (ev_stop) begin
            st_n = ST_IDLE;
        end else if (ev_start) begin
            st_n    = ST_ADDR;
            reload  = 1'b1;
            crc_clr = (st_q == ST_IDLE);
        end else if (rx_valid) begin
            ack_n.valid = 1'b1;
            unique case (st_q)
                ST_ADDR: begin
                    if (rx_byte[7:1] == dev_addr) begin
                        ack_n.ok = 1'b1;
                        crc_upd  = 1'b1;
                        if (rx_byte[0]) begin
                            st_n = ST_READ;
                            rd_n = blk_mode ? RD_COUNT : RD_DATA;
                        end else begin
                            st_n = ST_CMD;
                        end
                    end else begin
                        st_n = ST_TAIL;
                    end
                end
                ST_CMD: begin
                    ack_n.ok = 1'b1;
                    crc_upd  = 1'b1;
                    ld_ptr   = 1'b1;
                    st_n     = rx_byte[7] ? ST_CNT : ST_WDATA;
                end
                ST_WDATA: begin
                    ack_n.ok = 1'b1;
                    crc_upd  = 1'b1;
                    wbuf_n   = rx_byte;
                    if (pec_en) begin
                        st_n = ST_WPEC;
                    end else begin
                        reg_we = 1'b1;
                        st_n   = ST_TAIL;
                    end
                end
                ST_WPEC: begin
                    if (rx_byte == crc) begin
                        ack_n.ok  = 1'b1;
                        reg_we    = 1'b1;
                        reg_wdata = wbuf_q;
                    end
                    st_n = ST_TAIL;
                end
                ST_CNT: begin
                    ack_n.ok = 1'b1;
                    crc_upd  = 1'b1;
                    cnt_n    = cnt_rx;
                    if (cnt_rx == '0) begin
                        st_n = pec_en ? ST_BPEC : ST_TAIL;
                    end else begin
                        st_n = ST_BDATA;
                    end
                end
                ST_BDATA: begin
                    ack_n.ok = 1'b1;
                    crc_upd  = 1'b1;
                    reg_we   = 1'b1;
                    inc      = 1'b1;
                    cnt_n    = cnt_q - CW'(1);
                    if (cnt_q == CW'(1)) begin
                        st_n = pec_en ? ST_BPEC : ST_TAIL;
                    end
                end
                ST_BPEC: begin
                    ack_n.ok = (rx_byte == crc);
                    st_n     = ST_TAIL;
                end
                default: begin
                    ack_n.ok = 1'b0;
                end
            endcase
        end else if (tx_req) begin
            tx_n.valid = 1'b1;
            if (st_q == ST_READ) begin
                unique case (rd_q)
                    RD_COUNT: begin
                        tx_n.data = 8'(len_clamp);
                        crc_upd   = 1'b1;
                        crc_din   = 8'(len_clamp);
                        cnt_n     = len_clamp;
                        if (len_clamp == '0) begin
                            rd_n = pec_en ? RD_PEC : RD_DONE;
                        end else begin
                            rd_n = RD_DATA;
                        end
                    end
                    RD_DATA: begin
                        tx_n.data = reg_rdata;
                        crc_upd   = 1'b1;
                        crc_din   = reg_rdata;
                        if (blk_mode) begin
                            inc   = 1'b1;
                            cnt_n = cnt_q - CW'(1);
                            if (cnt_q == CW'(1)) begin
                                rd_n = pec_en ? RD_PEC : RD_DONE;
                            end
                        end else begin
                            rd_n = pec_en ? RD_PEC : RD_DONE;
                        end
                    end
                    RD_PEC: begin
                        tx_n.data = crc;
                        rd_n      = RD_DONE;
                    end
                    default: begin
                        tx_n.data = IDLE_FILL;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rd_q   <= RD_DONE;
            cnt_q  <= '0;
            wbuf_q <= 8'h00;
            ack_q  <= '{valid: 1'b0, ok: 1'b0};
            tx_q   <= '{valid: 1'b0, data: IDLE_FILL};
        end else begin
            st_q   <= st_n;
            rd_q   <= rd_n;
            cnt_q  <= cnt_n;
            wbuf_q <= wbuf_n;
            ack_q  <= ack_n;
            tx_q   <= tx_n;
        end
    end

    assign ack_valid = ack_q.valid;
    assign ack_ok    = ack_q.ok;
    assign tx_valid  = tx_q.valid;
    assign tx_byte   = tx_q.data;
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
    import smb_pkg::*;
#(
    parameter int NREG    = 96,
    parameter int MAX_BLK = 32,
    localparam int AW     = $clog2(NREG),
    localparam int CW     = $clog2(MAX_BLK + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [6:0]    dev_addr,
    input  logic          pec_en,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          tx_req,
    output logic          ack_valid,
    output logic          ack_ok,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic [AW-1:0] reg_addr,
    output logic          reg_we,
    output logic [7:0]    reg_wdata,
    input  logic [7:0]    reg_rdata
);
    logic          ld_ptr, reload, inc;
    logic          crc_clr, crc_upd;
    logic [7:0]    crc_din, crc;
    logic          blk_mode;
    logic [CW-1:0] len_clamp;
    logic [AW-1:0] wa;
    logic          len_we;

    // A committed write that lands on register 0 also sets the block length
    assign len_we   = reg_we && (wa == '0);
    assign reg_addr = wa;

    smb_fsm #(.MAX_BLK(MAX_BLK)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .dev_addr  (dev_addr),
        .pec_en    (pec_en),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .blk_mode  (blk_mode),
        .len_clamp (len_clamp),
        .crc       (crc),
        .reg_rdata (reg_rdata),
        .ack_valid (ack_valid),
        .ack_ok    (ack_ok),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ld_ptr    (ld_ptr),
        .reload    (reload),
        .inc       (inc),
        .crc_clr   (crc_clr),
        .crc_upd   (crc_upd),
        .crc_din   (crc_din)
    );

    smb_ptr #(.NREG(NREG), .MAX_BLK(MAX_BLK)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ld_ptr    (ld_ptr),
        .ptr_in    (rx_byte),
        .reload    (reload),
        .inc       (inc),
        .len_we    (len_we),
        .len_din   (reg_wdata),
        .blk_mode  (blk_mode),
        .wa        (wa),
        .len_clamp (len_clamp)
    );

    smb_crc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .upd (crc_upd),
        .din (crc_din),
        .crc (crc)
    );
endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk #(
    parameter int NREG = 96,
    localparam int AW  = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          tx_req,
    input logic          ack_valid,
    input logic          ack_ok,
    input logic          tx_valid,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr
);
    AST_ACK_NEXT:   assert property (@(posedge clk) disable iff (rst) rx_valid |=> ack_valid); // R10
    AST_ACK_CAUSE:  assert property (@(posedge clk) disable iff (rst) ack_valid |-> $past(rx_valid)); // R10
    AST_TX_NEXT:    assert property (@(posedge clk) disable iff (rst) tx_req |=> tx_valid); // R10
    AST_WE_ON_RX:   assert property (@(posedge clk) disable iff (rst) reg_we |-> rx_valid); // R1
    AST_WE_ACKED:   assert property (@(posedge clk) disable iff (rst) reg_we |=> (ack_valid && ack_ok)); // R9
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst) int'(reg_addr) < NREG); // R6
endmodule

bind smb_blk_slave smb_blk_slave_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .ack_valid (ack_valid),
    .ack_ok    (ack_ok),
    .tx_valid  (tx_valid),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr)
);

// File: tb/tb_smb_blk_slave.sv
`timescale 1ns/1ps
module tb_smb_blk_slave;
    localparam int NREG = 96;
    localparam int AW   = $clog2(NREG);
    localparam logic [6:0] DEV = 7'h2C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pec_en = 1'b0;
    logic          ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          ack_valid, ack_ok, tx_valid, reg_we;
    logic [7:0]    tx_byte, reg_wdata, reg_rdata;
    logic [AW-1:0] reg_addr;
    logic [7:0]    mem [NREG];
    logic [7:0]    expm [NREG];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    smb_blk_slave #(.NREG(NREG)) dut (
        .clk(clk), .rst(rst), .dev_addr(DEV), .pec_en(pec_en),
        .ev_start(ev_start), .ev_stop(ev_stop), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Bench register file
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end

    // Bit-serial CRC-8 reference, polynomial 0x07
    function automatic logic [7:0] crcb(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[7] ^ d[b];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic sta();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic sto();
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b, output bit ok);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
        chk(ack_valid === 1'b1, "R10 ack response", int'(ack_valid), 1);
        ok = ack_ok;
    endtask

    task automatic tx(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        chk(tx_valid === 1'b1, "R10 tx response", int'(tx_valid), 1);
        b = tx_byte;
    endtask

    task automatic write_byte(input logic [7:0] cmd, input logic [7:0] d, input bit pec,
                              input bit corrupt, output bit all_ok, output bit pec_ok);
        bit ok;
        logic [7:0] c = 8'h00;
        all_ok = 1;
        pec_ok = 1;
        sta();
        rx({DEV, 1'b0}, ok); all_ok &= ok; c = crcb(c, {DEV, 1'b0});
        rx(cmd, ok);         all_ok &= ok; c = crcb(c, cmd);
        rx(d, ok);           all_ok &= ok; c = crcb(c, d);
        if (pec) begin
            rx(corrupt ? (c ^ 8'h01) : c, ok);
            pec_ok = ok;
        end
        sto();
        if (pec_ok) expm[cmd[AW-1:0]] = d;
    endtask

    task automatic read_byte(input logic [7:0] cmd, input bit pec, input string req);
        bit ok;
        logic [7:0] c = 8'h00;
        logic [7:0] b;
        sta();
        rx({DEV, 1'b0}, ok); c = crcb(c, {DEV, 1'b0});
        rx(cmd, ok);         c = crcb(c, cmd);
        sta();
        rx({DEV, 1'b1}, ok); c = crcb(c, {DEV, 1'b1});
        tx(b);
        chk(b == expm[cmd[AW-1:0]], req, b, expm[cmd[AW-1:0]]);
        c = crcb(c, b);
        if (pec) begin
            tx(b);
            chk(b == c, "R8 read PEC", b, c);
        end
        sto();
    endtask

    task automatic recv_byte(input logic [7:0] expv, input string req);
        bit ok;
        logic [7:0] b;
        sta();
        rx({DEV, 1'b1}, ok);
        tx(b);
        chk(b == expv, req, b, expv);
        sto();
    endtask

    task automatic block_write(input int start, input logic [7:0] cnt, input int nsend,
                               input logic [7:0] seed, output int nack_at);
        bit ok;
        int a = start;
        nack_at = -1;
        sta();
        rx({DEV, 1'b0}, ok);
        rx(8'h80 | 8'(start), ok);
        rx(cnt, ok);
        for (int i = 0; i < nsend; i++) begin
            rx(seed + 8'(i * 17), ok);
            if (ok) begin
                expm[a] = seed + 8'(i * 17);
                a = (a == NREG - 1) ? 0 : a + 1;
            end else if (nack_at < 0) begin
                nack_at = i;
            end
        end
        sto();
    endtask

    task automatic block_read(input int start, input bit pec, input int expcnt, input string req);
        bit ok;
        logic [7:0] b;
        logic [7:0] c = 8'h00;
        int a = start;
        sta();
        rx({DEV, 1'b0}, ok);       c = crcb(c, {DEV, 1'b0});
        rx(8'h80 | 8'(start), ok); c = crcb(c, 8'h80 | 8'(start));
        sta();
        rx({DEV, 1'b1}, ok);       c = crcb(c, {DEV, 1'b1});
        tx(b); c = crcb(c, b);
        chk(int'(b) == expcnt, {req, " count"}, b, expcnt);
        for (int i = 0; i < expcnt; i++) begin
            tx(b); c = crcb(c, b);
            chk(b == expm[a], {req, " data"}, b, expm[a]);
            a = (a == NREG - 1) ? 0 : a + 1;
        end
        if (pec) begin
            tx(b);
            chk(b == c, "R8 block PEC", b, c);
        end
        tx(b);
        chk(b == 8'hFF, "R10 past end", b, 8'hFF);
        sto();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok, all_ok, pec_ok;
        int nack_at;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) expm[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ack_valid == 0 && tx_valid == 0 && reg_we == 0, "R10 reset state",
            {ack_valid, tx_valid, reg_we}, 0);
        rst = 1'b0;

        // R3: foreign address, whole frame refused and no write
        sta();
        rx({DEV ^ 7'h01, 1'b0}, ok); chk(!ok, "R3 foreign address NACK", ok, 0);
        rx(8'h05, ok);               chk(!ok, "R3 foreign cmd NACK", ok, 0);
        rx(8'hEE, ok);               chk(!ok, "R3 foreign data NACK", ok, 0);
        sto();
        chk(mem[5] == 8'h00, "R3 no write", mem[5], 0);

        // R1 write byte, R7 repeated receive byte
        write_byte(8'h05, 8'hA5, 0, 0, all_ok, pec_ok);
        chk(all_ok, "R1 write byte acks", all_ok, 1);
        chk(mem[5] == 8'hA5, "R1 register written", mem[5], 8'hA5);
        recv_byte(8'hA5, "R7 receive byte first");
        recv_byte(8'hA5, "R7 receive byte repeat");

        // R2 block write of three bytes
        block_write(10, 8'd3, 3, 8'h30, nack_at);
        chk(nack_at == -1, "R2 block data acks", nack_at, -1);
        chk(mem[10] == expm[10] && mem[11] == expm[11] && mem[12] == expm[12],
            "R2 block contents", mem[12], expm[12]);
        block_write(14, 8'd2, 3, 8'h60, nack_at);
        chk(nack_at == 2, "R10 byte after block NACK", nack_at, 2);

        // R5 count 40 limited to 32
        block_write(40, 8'd40, 33, 8'h01, nack_at);
        chk(nack_at == 32, "R5 write clamp NACK index", nack_at, 32);
        chk(mem[72] == 8'h00, "R5 no write past 32", mem[72], 0);

        // R6 wrap, and same-cycle write to register 0 sets block length
        sta();
        rx({DEV, 1'b0}, ok); rx(8'h80 | 8'(NREG - 2), ok); rx(8'd4, ok);
        rx(8'h11, ok); rx(8'h22, ok); rx(8'h03, ok); rx(8'h44, ok);
        chk(ok, "R6 wrapped byte ack", ok, 1);
        sto();
        expm[NREG-2] = 8'h11; expm[NREG-1] = 8'h22; expm[0] = 8'h03; expm[1] = 8'h44;
        chk(mem[0] == 8'h03 && mem[1] == 8'h44, "R6 wrap to register 0", mem[0], 8'h03);
        block_read(NREG - 2, 0, 3, "R4 R6 block read after wrap");

        // R5 read length limited to 32
        write_byte(8'h00, 8'd50, 0, 0, all_ok, pec_ok);
        block_read(10, 0, 32, "R5 read clamp");

        // R8 R9 packet error checking
        pec_en = 1'b1;
        write_byte(8'h07, 8'h5A, 1, 0, all_ok, pec_ok);
        chk(pec_ok, "R9 good PEC ACK", pec_ok, 1);
        chk(mem[7] == 8'h5A, "R9 good PEC commit", mem[7], 8'h5A);
        write_byte(8'h07, 8'h33, 1, 1, all_ok, pec_ok);
        chk(!pec_ok, "R9 bad PEC NACK", pec_ok, 0);
        chk(mem[7] == 8'h5A, "R9 bad PEC no commit", mem[7], 8'h5A);
        read_byte(8'h07, 1, "R8 read byte with PEC");
        write_byte(8'h00, 8'd5, 1, 0, all_ok, pec_ok);
        block_read(20, 1, 5, "R8 block read with PEC");
        pec_en = 1'b0;

        // Random single-byte traffic
        for (int n = 0; n < 40; n++) begin
            logic [7:0] a = 8'(1 + ($urandom % (NREG - 1)));
            logic [7:0] d = 8'($urandom);
            pec_en = 1'($urandom);
            write_byte(a, d, pec_en, 0, all_ok, pec_ok);
            chk(all_ok && pec_ok, "R1 random write acks", all_ok, 1);
            read_byte(a, pec_en, "R1 R7 random readback");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule